// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous Static Memory

This block is a clocked static memory with a pipelined read path. Select, direction, write enables and address are sampled together on the rising clock edge. A read's data is loaded into an output register on the next edge. A write's data is not sampled with its command. It is sampled one edge later and parked in a single-entry write buffer. The buffer is copied into the array when the next write's data arrives, or on the first idle (deselected) cycle.

A read that hits the parked address is served from the buffer for the lanes that write enabled and from the array for the rest, so the late write is never visible as stale data. The word is made of 9-bit lanes, each with its own write enable, and a global write enable that writes every lane. Output enable and a sleep input act on the output driver enable without waiting for a clock. Sleep also stops all operations. The pad driver is modelled as a data bus plus a drive-enable bit.

Top module: `lwsram`

## Requirements
- R1: A read command (sel_i=1, wr_i=0) sampled on clock edge k loads the addressed word into the output register on edge k+1, so dq_o shows it after edge k+1.
- R2: The data of a write command sampled on edge k is taken from wdata_i on edge k+1.
- R3: Lane i covers bits [9i+8:9i] of the word, so lane 0 is bits 0-8 and lane 3 is bits 27-35 at 36 bits. A write changes only the lanes whose bit i of lane_we_i is 1, and leaves the other lanes of the addressed word unchanged. A write with no lane bit set and gwe_i=0 changes nothing.
- R4: gwe_i=1 on a write writes every lane, whatever lane_we_i holds.
- R5: A cycle with sel_i=0, or a write cycle, does not load the output register, so dq_o keeps its previous value.
- R6: A read of the address held in the write buffer returns the buffered data for that write's enabled lanes and array contents for its other lanes.
- R7: The write buffer holds one write. It is copied to the array when the next write's data arrives, or on an edge with sel_i=0. It is kept through read cycles, so back-to-back writes and later reads all see every write.
- R8: When oe_i=0, dq_en_o is 0 at once, without a clock edge.
- R9: While sleep_i=1, dq_en_o is 0 at once, and no command, write data or buffer commit is taken on any edge. A read or write in flight when sleep rises is dropped, and the array and dq_o keep their contents.
- R10: An active-low rst_n clears the output register to zero and empties the write buffer as soon as it is asserted. Release takes effect after two clock edges. The array is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sel_i | input | 1 | Synchronous select; 0 makes the cycle idle |
| wr_i | input | 1 | 1 = write command, 0 = read command |
| gwe_i | input | 1 | Global write enable, writes all lanes |
| lane_we_i | input | DATA_W/9 | Per-lane write enables, bit i for lane i |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data, one cycle after its command |
| oe_i | input | 1 | Asynchronous output enable |
| sleep_i | input | 1 | Asynchronous sleep |
| dq_o | output | DATA_W | Output register contents |
| dq_en_o | output | 1 | Output driver enable (0 = high impedance) |

## Verification
The assertions assume that sel_i, wr_i and sleep_i are driven to known values from time zero and change only away from the rising edge. They also assume that the array is never read at a lane that has not been written since power-up. The bench therefore drives every input at the falling edge. It begins with global writes that fill each address it later reads, so every lane that a partial write leaves alone already holds a known value. Sleep and output enable are toggled between edges, so their immediate effect on dq_en_o can be observed without a clock.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  localparam int LANE_W = 9;

  function automatic int lanes_of(input int width);
    return width / LANE_W;
  endfunction
endpackage

// File: rtl/lwsram_ctl.sv
module lwsram_ctl #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sel,
  input  logic              wr,
  input  logic              gwe,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_vld,
  output logic              wp_vld,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_mask,
  output logic              idle
);
  logic              rd_vld_d, wp_vld_d;
  logic [ADDR_W-1:0] addr_d;
  logic [LANES-1:0]  mask_d;
  logic              cap_en;

  always_comb begin
    cap_en   = run & sel;
    rd_vld_d = cap_en & ~wr;
    wp_vld_d = cap_en & wr;
    addr_d   = cap_en ? addr : cmd_addr;
    mask_d   = cmd_mask;
    if (cap_en && wr) mask_d = gwe ? {LANES{1'b1}} : lane_we;
    idle     = run & ~sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld   <= 1'b0;
      wp_vld   <= 1'b0;
      cmd_addr <= '0;
      cmd_mask <= '0;
    end else begin
      rd_vld   <= rd_vld_d;
      wp_vld   <= wp_vld_d;
      cmd_addr <= addr_d;
      cmd_mask <= mask_d;
    end
  end
endmodule

// File: rtl/lwsram_wbuf.sv
module lwsram_wbuf
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wp_vld,
  input  logic              idle,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LANES-1:0]  cmd_mask,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     arr_word,
  output logic [DW-1:0]     rd_word,
  output logic              buf_vld,
  output logic              commit,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [LANES-1:0]  buf_mask,
  output logic [DW-1:0]     buf_data
);
  logic              load;
  logic              vld_d;
  logic [ADDR_W-1:0] addr_d;
  logic [LANES-1:0]  mask_d;
  logic [DW-1:0]     data_d;
  logic              hit;

  always_comb begin
    load   = run & wp_vld;
    commit = run & buf_vld & (load | idle);
    vld_d  = buf_vld;
    addr_d = buf_addr;
    mask_d = buf_mask;
    data_d = buf_data;
    if (load) begin
      vld_d  = 1'b1;
      addr_d = cmd_addr;
      mask_d = cmd_mask;
      data_d = wdata;
    end else if (commit) begin
      vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_vld  <= 1'b0;
      buf_addr <= '0;
      buf_mask <= '0;
      buf_data <= '0;
    end else begin
      buf_vld  <= vld_d;
      buf_addr <= addr_d;
      buf_mask <= mask_d;
      buf_data <= data_d;
    end
  end

  assign hit = buf_vld && (buf_addr == cmd_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign rd_word[l*LANE_W +: LANE_W] = (hit && buf_mask[l]) ? buf_data[l*LANE_W +: LANE_W]
                                                             : arr_word[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lwsram_mem.sv
module lwsram_mem
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANES-1:0]  wmask,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic              lane_en;

    assign lane_en = we & wmask[l];

    always_ff @(posedge clk) begin
      if (lane_en) cells[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = cells[raddr];
  end
endmodule

// File: rtl/lwsram.sv
module lwsram
  import lwsram_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_i,
  input  logic                     wr_i,
  input  logic                     gwe_i,
  input  logic [DATA_W/LANE_W-1:0] lane_we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     oe_i,
  input  logic                     sleep_i,
  output logic [DATA_W-1:0]        dq_o,
  output logic                     dq_en_o
);
  localparam int LANES = lanes_of(DATA_W);

  logic [1:0]        rst_pipe;
  logic              rst_i;
  logic              run;
  logic              rd_vld, wp_vld, idle;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]  cmd_mask;
  logic [DATA_W-1:0] arr_word, rd_word;
  logic              buf_vld, commit;
  logic [ADDR_W-1:0] buf_addr;
  logic [LANES-1:0]  buf_mask;
  logic [DATA_W-1:0] buf_data;
  logic [DATA_W-1:0] out_q, out_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  assign run = ~sleep_i;

  lwsram_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk(clk), .rst_n(rst_i), .run(run), .sel(sel_i), .wr(wr_i), .gwe(gwe_i),
    .lane_we(lane_we_i), .addr(addr_i), .rd_vld(rd_vld), .wp_vld(wp_vld),
    .cmd_addr(cmd_addr), .cmd_mask(cmd_mask), .idle(idle)
  );

  lwsram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wbuf (
    .clk(clk), .rst_n(rst_i), .run(run), .wp_vld(wp_vld), .idle(idle),
    .cmd_addr(cmd_addr), .cmd_mask(cmd_mask), .wdata(wdata_i),
    .arr_word(arr_word), .rd_word(rd_word), .buf_vld(buf_vld), .commit(commit),
    .buf_addr(buf_addr), .buf_mask(buf_mask), .buf_data(buf_data)
  );

  lwsram_mem #(.ADDR_W(ADDR_W), .LANES(LANES)) u_mem (
    .clk(clk), .we(commit), .waddr(buf_addr), .wmask(buf_mask), .wdata(buf_data),
    .raddr(cmd_addr), .rdata(arr_word)
  );

  always_comb begin
    out_d = out_q;
    if (run && rd_vld) out_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) out_q <= '0;
    else        out_q <= out_d;
  end

  assign dq_o    = out_q;
  assign dq_en_o = oe_i & ~sleep_i;
endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_i,
  input logic              sel_i,
  input logic              wr_i,
  input logic              oe_i,
  input logic              sleep_i,
  input logic              wp_vld,
  input logic              buf_vld,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_en_o
);
  // R8: output enable low keeps the driver off
  a_r8_oe_off: assert property (@(posedge clk) disable iff (!rst_i)
    !oe_i |-> !dq_en_o);

  // R9: sleeping edges leave the output register untouched
  a_r9_sleep_hold: assert property (@(posedge clk) disable iff (!rst_i)
    sleep_i |=> $stable(dq_o));

  // R5: idle or write command never reloads the output on the following edge
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_i)
    (!sel_i || wr_i) |=> ##1 $stable(dq_o));

  // R2: pending write command captures its data on the next awake edge
  a_r2_data_taken: assert property (@(posedge clk) disable iff (!rst_i)
    (wp_vld && !sleep_i) |=> buf_vld);

  // R7: a read cycle with no new write data keeps the buffer
  a_r7_buf_kept: assert property (@(posedge clk) disable iff (!rst_i)
    (buf_vld && !sleep_i && sel_i && !wr_i && !wp_vld) |=> buf_vld);

  // R10: in reset the output register is clear and the buffer empty
  always @(posedge clk) begin
    if (!rst_i) begin
      a_r10_reset_clear: assert (dq_o == '0 && !buf_vld);
    end
  end
endmodule

bind lwsram lwsram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_i(rst_i), .sel_i(sel_i), .wr_i(wr_i), .oe_i(oe_i),
  .sleep_i(sleep_i), .wp_vld(wp_vld), .buf_vld(buf_vld), .dq_o(dq_o),
  .dq_en_o(dq_en_o)
);

// File: tb/lwsram_bench.sv
`timescale 1ns/1ps
module lwsram_bench;
  localparam int DW = 36;
  localparam int AW = 4;
  localparam int NL = DW / 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_i, wr_i, gwe_i, oe_i, sleep_i;
  logic [NL-1:0] lane_we_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i;
  logic [DW-1:0] dq_o;
  logic          dq_en_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lwsram #(.DATA_W(DW), .ADDR_W(AW)) u_lwsram (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i), .gwe_i(gwe_i),
    .lane_we_i(lane_we_i), .addr_i(addr_i), .wdata_i(wdata_i), .oe_i(oe_i),
    .sleep_i(sleep_i), .dq_o(dq_o), .dq_en_o(dq_en_o)
  );

  typedef struct packed {
    logic          chk;
    logic          sel;
    logic          wr;
    logic          gwe;
    logic [3:0]    we;
    logic [3:0]    addr;
    logic [35:0]   wd;
    logic [35:0]   exp;
  } vec_t;

  // one row per cycle; exp is dq_o just after that row's edge
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,1'b1,4'h0,4'h2,36'h0,36'h0},            // v0  write A2 all lanes
    '{1'b0,1'b1,1'b1,1'b1,4'h0,4'h1,36'h0,36'h0},            // v1  write A1 all lanes, data A2=0
    '{1'b0,1'b1,1'b1,1'b0,4'h3,4'h2,36'h123456789,36'h0},    // v2  write A2 lanes0,1, data A1
    '{1'b0,1'b1,1'b0,1'b0,4'h0,4'h2,36'hFFFFFFFFF,36'h0},    // v3  read A2, data for A2
    '{1'b1,1'b1,1'b0,1'b0,4'h0,4'h1,36'h0,36'h00003FFFF},    // v4  R6 R3 bypass merge
    '{1'b1,1'b0,1'b0,1'b0,4'h0,4'h0,36'h0,36'h123456789},    // v5  R1 R7 A1 from array
    '{1'b1,1'b1,1'b0,1'b0,4'h0,4'h2,36'h0,36'h123456789},    // v6  R5 idle hold
    '{1'b1,1'b0,1'b0,1'b0,4'h0,4'h0,36'h0,36'h00003FFFF},    // v7  R7 idle commit
    '{1'b0,1'b1,1'b1,1'b1,4'h8,4'h1,36'h0,36'h0},            // v8  write A1 gwe, lane3 only set
    '{1'b1,1'b1,1'b0,1'b0,4'h0,4'h1,36'h555555555,36'h00003FFFF}, // v9 R5 write holds
    '{1'b1,1'b0,1'b0,1'b0,4'h0,4'h0,36'h0,36'h555555555},    // v10 R4 all lanes
    '{1'b1,1'b1,1'b1,1'b0,4'h4,4'h2,36'h0,36'h555555555},    // v11 write A2 lane2
    '{1'b1,1'b1,1'b0,1'b0,4'h0,4'h2,36'hAAAAAAAAA,36'h555555555}, // v12 read A2
    '{1'b1,1'b0,1'b0,1'b0,4'h0,4'h0,36'h0,36'h002ABFFFF},    // v13 R3 lane2 only
    '{1'b1,1'b1,1'b0,1'b0,4'h0,4'h1,36'h0,36'h002ABFFFF},    // v14 read A1
    '{1'b1,1'b0,1'b0,1'b0,4'h0,4'h0,36'h0,36'h555555555},    // v15 R1 A1
    '{1'b1,1'b1,1'b1,1'b0,4'h1,4'h1,36'h0,36'h555555555},    // v16 write A1 lane0
    '{1'b1,1'b1,1'b0,1'b0,4'h0,4'h1,36'h0,36'h555555555},    // v17 read A1 at data edge
    '{1'b1,1'b0,1'b0,1'b0,4'h0,4'h0,36'h0,36'h555555400},    // v18 R6 R2 back-to-back
    '{1'b1,1'b1,1'b1,1'b0,4'h0,4'h2,36'h0,36'h555555400},    // v19 write A2 no lanes
    '{1'b1,1'b1,1'b0,1'b0,4'h0,4'h2,36'hFFFFFFFFF,36'h555555400}, // v20 read A2
    '{1'b1,1'b0,1'b0,1'b0,4'h0,4'h0,36'h0,36'h002ABFFFF}     // v21 R3 empty mask no change
  };

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic s, input logic w, input logic g, input logic [NL-1:0] we,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    sel_i = s; wr_i = w; gwe_i = g; lane_we_i = we; addr_i = a; wdata_i = d;
  endtask

  task automatic tick_check(input string req, input logic [DW-1:0] exp);
    @(posedge clk); #1;
    check(req, dq_o, exp);
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; oe_i = 1'b1; sleep_i = 1'b0;
    drive(1'b0, 1'b0, 1'b0, '0, '0, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 dq after reset", dq_o, '0);
    check("R10 en after reset", {35'b0, dq_en_o}, 36'h1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i].sel, VEC[i].wr, VEC[i].gwe, VEC[i].we, VEC[i].addr, VEC[i].wd);
      @(posedge clk); #1;
      if (VEC[i].chk) check($sformatf("R1/R3/R4/R5/R6/R7 row %0d", i), dq_o, VEC[i].exp);
    end

    // R8 asynchronous output enable
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, '0, '0, '0);
    #0.5 oe_i = 1'b0; #0.5;
    check("R8 oe low", {35'b0, dq_en_o}, 36'h0);
    check("R8 data kept", dq_o, 36'h002ABFFFF);
    oe_i = 1'b1; #0.5;
    check("R8 oe high", {35'b0, dq_en_o}, 36'h1);

    // R9 sleep: driver off, write and read ignored
    @(negedge clk);
    sleep_i = 1'b1; #0.5;
    check("R9 en off", {35'b0, dq_en_o}, 36'h0);
    drive(1'b1, 1'b1, 1'b1, '0, 4'h1, '0);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, '0, 4'h1, 36'hFFFFFFFFF);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, '0, '0, '0);
    tick_check("R9 dq frozen", 36'h002ABFFFF);
    @(negedge clk);
    sleep_i = 1'b0;
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, '0, 4'h1, '0);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, '0, '0, '0);
    tick_check("R9 write dropped", 36'h555555400);
    check("R9 en back", {35'b0, dq_en_o}, 36'h1);

    // R10 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0; #0.5;
    check("R10 async clear", dq_o, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 stays clear", dq_o, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule